// File: doc/BRIEF.md
# Serial Port FIFO with Watermarks

This block is the data FIFO that sits between a synchronous serial shifter and the system side (processor bus or DMA) of a serial port. It holds 32 words of 32 bits and is built in one of two directions. The transmit build lets the bus push words and the shifter pop them. The receive build lets the shifter push words and the bus pop them. The control words come in through simple write strobes:

- an operation word that clears the FIFO and starts it;
- a configuration word carrying a lane-width code and a threshold;
- a watermark word carrying three 5-bit level marks.

The block reports its fill level and full and empty bits through a status word. It also raises a threshold flag, full and empty flags, sticky overflow and underflow flags, and one hit flag per watermark. For a receive FIFO every level comparison is "level at or above the reference", which asks for draining. For a transmit FIFO it is "level at or below the reference", which asks for refilling. Software stops the FIFO by writing zero to the operation word, which keeps the stored data. It clears the FIFO by writing the clear bit and then zero.

Top module: `serfifo_wm`

## Requirements
- R1: After reset the level is 0. The status word is 0x100 (empty set, full clear), the overflow and underflow flags are 0 and the FIFO is stopped. The width code is 2, the threshold is 16, and the watermarks (stop, low, high) are 4/14/27 for a receive build and 27/14/4 for a transmit build.
- R2: The status word is {empty, full, level}: level in bits 6:0, full in bit 7 (level equals 32) and empty in bit 8 (level equals 0). full_irq and empty_irq follow bits 7 and 8.
- R3: Words leave in the order they were accepted. Each word is masked at push by the width code in configuration bits 1:0: code 0 keeps bits 7:0, code 1 keeps bits 15:0, codes 2 and 3 keep all 32 bits.
- R4: Operation word: bit 0 is clear and bit 1 is start. While the stored bit 0 is set, the FIFO is emptied on every clock, pushes are ignored and both sticky flags are cleared. Writing 0 stops the FIFO and leaves its contents and level intact. The FIFO runs only with bit 1 set and bit 0 clear.
- R5: While the FIFO is not running, shifter-side requests neither push nor pop and do not move the level. The bus side still pushes (transmit) or pops (receive).
- R6: A push when the level is 32 and no pop is accepted in the same cycle is dropped. The level stays at 32 and the overflow flag is set until the next clear.
- R7: A pop at level 0 returns 0 on the read data port the cycle after the request and sets the underflow flag until the next clear.
- R8: The threshold is configuration bits 8:2. thr_irq is level ≥ threshold in a receive build and level ≤ threshold in a transmit build.
- R9: Watermark word bits 4:0, 14:10 and 24:20 hold the stop, low and high marks. mark_hit[0], [1] and [2] compare the level against them in the same direction as R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_wr | input | 1 | Operation word write strobe |
| op_wdata | input | 2 | Operation word: bit 1 start, bit 0 clear |
| cfg_wr | input | 1 | Configuration word write strobe |
| cfg_wdata | input | 9 | Threshold in bits 8:2, width code in bits 1:0 |
| mark_wr | input | 1 | Watermark word write strobe |
| mark_wdata | input | 25 | Marks at bits 4:0, 14:10, 24:20 |
| bus_req | input | 1 | Bus side request: push (transmit) or pop (receive) |
| bus_wdata | input | 32 | Bus push data (transmit) |
| bus_rdata | output | 32 | Bus pop data, valid the cycle after a pop (receive); 0 in a transmit build |
| sh_req | input | 1 | Shifter side request: pop (transmit) or push (receive) |
| sh_wdata | input | 32 | Shifter push data (receive) |
| sh_rdata | output | 32 | Shifter pop data, valid the cycle after a pop (transmit); 0 in a receive build |
| status | output | 9 | {empty, full, level[6:0]} |
| thr_irq | output | 1 | Threshold flag |
| full_irq | output | 1 | FIFO full |
| empty_irq | output | 1 | FIFO empty |
| ovf_flag | output | 1 | Sticky overflow |
| udf_flag | output | 1 | Sticky underflow |
| mark_hit | output | 3 | Watermark hits (stop, low, high) |

## Verification
The embedded properties assume that the strobes are driven from the same clock and are free of X once reset is released. They also assume the reset is held for at least one edge. The stop-hold property further assumes that nothing on the bus side is requested in the cycles it checks. The stimulus drives each strobe for exactly one cycle on the falling edge, with an idle cycle between requests, and never pulses op_wr together with a data request. A stop, clear or configuration change therefore never lands in the same cycle as a push or pop, and the bench's level model stays exact.

// File: rtl/serfifo_pkg.sv
package serfifo_pkg;

    parameter int unsigned FIFO_ENTRIES = 32;
    parameter int unsigned WORD_BITS    = 32;
    parameter int unsigned LEVEL_BITS   = 7;
    parameter int unsigned MARK_BITS    = 5;
    parameter int unsigned NUM_MARKS    = 3;
    parameter int unsigned MARK_STRIDE  = 10;
    parameter int unsigned THR_LSB      = 2;

    typedef enum logic [1:0] {
        W_BYTE     = 2'd0,
        W_HALF     = 2'd1,
        W_WORD     = 2'd2,
        W_WORD_ALT = 2'd3
    } width_e;

    // packed: start is bit 1, clear is bit 0
    typedef struct packed {
        logic start;
        logic clear;
    } opword_t;

    function automatic logic [WORD_BITS-1:0] lane_mask(width_e w, logic [WORD_BITS-1:0] d);
        case (w)
            W_BYTE:  return {{(WORD_BITS-8){1'b0}}, d[7:0]};
            W_HALF:  return {{(WORD_BITS-16){1'b0}}, d[15:0]};
            default: return d;
        endcase
    endfunction

    function automatic logic level_hit(logic rx_dir, logic [LEVEL_BITS-1:0] lvl,
                                       logic [LEVEL_BITS-1:0] ref_v);
        return rx_dir ? (lvl >= ref_v) : (lvl <= ref_v);
    endfunction

    function automatic logic [MARK_BITS-1:0] mark_default(logic rx_dir, int idx);
        case (idx)
            0:       return rx_dir ? MARK_BITS'(4)  : MARK_BITS'(27);
            1:       return MARK_BITS'(14);
            default: return rx_dir ? MARK_BITS'(27) : MARK_BITS'(4);
        endcase
    endfunction

endpackage

// File: rtl/serfifo_cfg.sv
module serfifo_cfg
    import serfifo_pkg::*;
#(
    parameter bit          IS_RX   = 1'b0,
    parameter int unsigned DEPTH   = FIFO_ENTRIES,
    parameter int unsigned LVL_W   = LEVEL_BITS,
    parameter int unsigned MARK_W  = MARK_BITS,
    parameter int unsigned N_MARKS = NUM_MARKS,
    parameter int unsigned STRIDE  = MARK_STRIDE,
    localparam int unsigned CFG_W  = LVL_W + THR_LSB,
    localparam int unsigned MWORD_W = (N_MARKS - 1) * STRIDE + MARK_W
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           op_wr,
    input  logic [1:0]                     op_wdata,
    input  logic                           cfg_wr,
    input  logic [CFG_W-1:0]               cfg_wdata,
    input  logic                           mark_wr,
    input  logic [MWORD_W-1:0]             mark_wdata,
    output opword_t                        op_q,
    output width_e                         wid_q,
    output logic [LVL_W-1:0]               thr_q,
    output logic [N_MARKS-1:0][MARK_W-1:0] marks_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q  <= '0;
            wid_q <= W_WORD;
            thr_q <= LVL_W'(DEPTH / 2);
            for (int k = 0; k < int'(N_MARKS); k++)
                marks_q[k] <= mark_default(IS_RX, k);
        end else begin
            if (op_wr)
                op_q <= opword_t'(op_wdata);
            if (cfg_wr) begin
                wid_q <= width_e'(cfg_wdata[1:0]);
                thr_q <= cfg_wdata[THR_LSB +: LVL_W];
            end
            if (mark_wr)
                for (int k = 0; k < int'(N_MARKS); k++)
                    marks_q[k] <= mark_wdata[k*STRIDE +: MARK_W];
        end
    end

endmodule

// File: rtl/serfifo_store.sv
module serfifo_store #(
    parameter int unsigned DEPTH = 32,
    parameter int unsigned DW    = 32,
    parameter int unsigned LVL_W = 7,
    localparam int unsigned AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             push,
    input  logic [DW-1:0]    push_data,
    input  logic             pop,
    output logic [DW-1:0]    pop_data,
    output logic [LVL_W-1:0] level,
    output logic             ovf,
    output logic             udf
);

    localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);
    localparam logic [AW-1:0]    LAST_IDX = AW'(DEPTH - 1);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          pop_ok, push_ok;

    assign pop_ok  = pop & ~clr & (level != '0);
    assign push_ok = push & ~clr & ((level != FULL_LVL) | pop_ok);

    always_ff @(posedge clk) begin
        if (push_ok)
            mem[wp] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wp       <= '0;
            rp       <= '0;
            level    <= '0;
            ovf      <= 1'b0;
            udf      <= 1'b0;
            pop_data <= '0;
        end else begin
            if (push_ok)
                wp <= (wp == LAST_IDX) ? '0 : wp + 1'b1;
            if (pop_ok) begin
                pop_data <= mem[rp];
                rp       <= (rp == LAST_IDX) ? '0 : rp + 1'b1;
            end else if (pop) begin
                pop_data <= '0;
                udf      <= 1'b1;
            end
            if (push && !push_ok)
                ovf <= 1'b1;
            level <= level + LVL_W'(push_ok) - LVL_W'(pop_ok);
        end
    end

    // R2
    lvl_bound_chk: assert property (@(posedge clk) disable iff (rst)
        level <= FULL_LVL);

    // R4
    clr_empties_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (level == '0) && !ovf && !udf);

    // R6
    full_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (level == FULL_LVL && push && !pop && !clr) |=> (level == FULL_LVL) && ovf);

    // R6
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (ovf && !clr) |=> ovf);

    // R7
    empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
        (level == '0 && pop && !push && !clr) |=> (pop_data == '0) && udf && (level == '0));

endmodule

// File: rtl/serfifo_mark_cmp.sv
module serfifo_mark_cmp
    import serfifo_pkg::*;
#(
    parameter bit          IS_RX = 1'b0,
    parameter int unsigned LVL_W = LEVEL_BITS,
    parameter int unsigned REF_W = MARK_BITS
) (
    input  logic [LVL_W-1:0] lvl,
    input  logic [REF_W-1:0] ref_v,
    output logic             hit
);

    assign hit = level_hit(IS_RX, LEVEL_BITS'(lvl), LEVEL_BITS'(ref_v));

endmodule

// File: rtl/serfifo_wm.sv
module serfifo_wm
    import serfifo_pkg::*;
#(
    parameter bit          IS_RX   = 1'b0,
    parameter int unsigned DEPTH   = FIFO_ENTRIES,
    parameter int unsigned DW      = WORD_BITS,
    parameter int unsigned LVL_W   = LEVEL_BITS,
    parameter int unsigned MARK_W  = MARK_BITS,
    parameter int unsigned N_MARKS = NUM_MARKS,
    parameter int unsigned STRIDE  = MARK_STRIDE,
    localparam int unsigned CFG_W   = LVL_W + THR_LSB,
    localparam int unsigned MWORD_W = (N_MARKS - 1) * STRIDE + MARK_W,
    localparam int unsigned STAT_W  = LVL_W + 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               op_wr,
    input  logic [1:0]         op_wdata,
    input  logic               cfg_wr,
    input  logic [CFG_W-1:0]   cfg_wdata,
    input  logic               mark_wr,
    input  logic [MWORD_W-1:0] mark_wdata,
    input  logic               bus_req,
    input  logic [DW-1:0]      bus_wdata,
    output logic [DW-1:0]      bus_rdata,
    input  logic               sh_req,
    input  logic [DW-1:0]      sh_wdata,
    output logic [DW-1:0]      sh_rdata,
    output logic [STAT_W-1:0]  status,
    output logic               thr_irq,
    output logic               full_irq,
    output logic               empty_irq,
    output logic               ovf_flag,
    output logic               udf_flag,
    output logic [N_MARKS-1:0] mark_hit
);

    opword_t                        op_q;
    width_e                         wid_q;
    logic [LVL_W-1:0]               thr_q;
    logic [N_MARKS-1:0][MARK_W-1:0] marks_q;
    logic                           run, clr;
    logic                           push, pop;
    logic [DW-1:0]                  push_raw, pop_data;
    logic [LVL_W-1:0]               level;

    serfifo_cfg #(
        .IS_RX(IS_RX), .DEPTH(DEPTH), .LVL_W(LVL_W), .MARK_W(MARK_W),
        .N_MARKS(N_MARKS), .STRIDE(STRIDE)
    ) u_cfg (
        .clk, .rst, .op_wr, .op_wdata, .cfg_wr, .cfg_wdata, .mark_wr, .mark_wdata,
        .op_q, .wid_q, .thr_q, .marks_q
    );

    assign clr = op_q.clear;
    assign run = op_q.start & ~op_q.clear;

    // direction picks which side writes and which side reads
    assign push     = IS_RX ? (sh_req & run) : bus_req;
    assign pop      = IS_RX ? bus_req : (sh_req & run);
    assign push_raw = IS_RX ? sh_wdata : bus_wdata;

    assign bus_rdata = IS_RX ? pop_data : '0;
    assign sh_rdata  = IS_RX ? '0 : pop_data;

    serfifo_store #(.DEPTH(DEPTH), .DW(DW), .LVL_W(LVL_W)) u_store (
        .clk, .rst, .clr,
        .push, .push_data(lane_mask(wid_q, push_raw)), .pop,
        .pop_data, .level, .ovf(ovf_flag), .udf(udf_flag)
    );

    assign full_irq  = (level == LVL_W'(DEPTH));
    assign empty_irq = (level == '0);
    assign status    = {empty_irq, full_irq, level};

    serfifo_mark_cmp #(.IS_RX(IS_RX), .LVL_W(LVL_W), .REF_W(LVL_W)) u_thr (
        .lvl(level), .ref_v(thr_q), .hit(thr_irq)
    );

    for (genvar k = 0; k < int'(N_MARKS); k++) begin : g_mark
        serfifo_mark_cmp #(.IS_RX(IS_RX), .LVL_W(LVL_W), .REF_W(MARK_W)) u_mk (
            .lvl(level), .ref_v(marks_q[k]), .hit(mark_hit[k])
        );
    end

    // R5
    stop_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!run && !bus_req && !clr) |=> (level == $past(level)));

    // R4
    stop_keeps_chk: assert property (@(posedge clk) disable iff (rst)
        (op_wr && op_wdata == 2'b00 && !clr && !bus_req && !sh_req && level != '0)
        |=> (level == $past(level)) && (level != '0));

    // R2
    flags_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(full_irq && empty_irq));

endmodule

// File: tb/serfifo_wm_tb_top.sv
`timescale 1ns/1ps
module serfifo_wm_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    int n_chk  = 0;
    int n_fail = 0;

    // transmit build (dut_i)
    logic        t_op_wr = 0, t_cfg_wr = 0, t_mark_wr = 0, t_bus_req = 0, t_sh_req = 0;
    logic [1:0]  t_op_wdata = 0;
    logic [8:0]  t_cfg_wdata = 0;
    logic [24:0] t_mark_wdata = 0;
    logic [31:0] t_bus_wdata = 0, t_sh_wdata = 0;
    logic [31:0] t_bus_rdata, t_sh_rdata;
    logic [8:0]  t_status;
    logic        t_thr, t_full, t_empty, t_ovf, t_udf;
    logic [2:0]  t_hit;

    // receive build
    logic        r_op_wr = 0, r_cfg_wr = 0, r_mark_wr = 0, r_bus_req = 0, r_sh_req = 0;
    logic [1:0]  r_op_wdata = 0;
    logic [8:0]  r_cfg_wdata = 0;
    logic [24:0] r_mark_wdata = 0;
    logic [31:0] r_bus_wdata = 0, r_sh_wdata = 0;
    logic [31:0] r_bus_rdata, r_sh_rdata;
    logic [8:0]  r_status;
    logic        r_thr, r_full, r_empty, r_ovf, r_udf;
    logic [2:0]  r_hit;

    serfifo_wm #(.IS_RX(1'b0)) dut_i (
        .clk, .rst, .op_wr(t_op_wr), .op_wdata(t_op_wdata), .cfg_wr(t_cfg_wr),
        .cfg_wdata(t_cfg_wdata), .mark_wr(t_mark_wr), .mark_wdata(t_mark_wdata),
        .bus_req(t_bus_req), .bus_wdata(t_bus_wdata), .bus_rdata(t_bus_rdata),
        .sh_req(t_sh_req), .sh_wdata(t_sh_wdata), .sh_rdata(t_sh_rdata),
        .status(t_status), .thr_irq(t_thr), .full_irq(t_full), .empty_irq(t_empty),
        .ovf_flag(t_ovf), .udf_flag(t_udf), .mark_hit(t_hit)
    );

    serfifo_wm #(.IS_RX(1'b1)) rx_i (
        .clk, .rst, .op_wr(r_op_wr), .op_wdata(r_op_wdata), .cfg_wr(r_cfg_wr),
        .cfg_wdata(r_cfg_wdata), .mark_wr(r_mark_wr), .mark_wdata(r_mark_wdata),
        .bus_req(r_bus_req), .bus_wdata(r_bus_wdata), .bus_rdata(r_bus_rdata),
        .sh_req(r_sh_req), .sh_wdata(r_sh_wdata), .sh_rdata(r_sh_rdata),
        .status(r_status), .thr_irq(r_thr), .full_irq(r_full), .empty_irq(r_empty),
        .ovf_flag(r_ovf), .udf_flag(r_udf), .mark_hit(r_hit)
    );

    // bench model of the transmit build
    logic [31:0] exp_q[$];
    int          tx_lvl = 0;
    bit          tx_run = 0;
    bit          tx_clr = 0;
    logic [1:0]  tx_wid = 2'd2;
    event        pop_ev;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [8:0] stat_of(int lvl);
        return {lvl == 0, lvl == 32, 7'(lvl)};
    endfunction

    task automatic tx_op(input logic [1:0] v);
        @(negedge clk); t_op_wr = 1; t_op_wdata = v;
        @(negedge clk); t_op_wr = 0;
        tx_clr = v[0];
        tx_run = v[1] & ~v[0];
        if (v[0]) begin exp_q.delete(); tx_lvl = 0; end
    endtask

    task automatic tx_cfg(input logic [1:0] w, input int thr);
        @(negedge clk); t_cfg_wr = 1; t_cfg_wdata = {7'(thr), w};
        @(negedge clk); t_cfg_wr = 0;
        tx_wid = w;
    endtask

    // driver: pushes the expected masked word into the scoreboard
    task automatic tx_push(input logic [31:0] d);
        logic [31:0] m;
        @(negedge clk); t_bus_req = 1; t_bus_wdata = d;
        @(negedge clk); t_bus_req = 0;
        case (tx_wid)
            2'd0:    m = {24'h0, d[7:0]};
            2'd1:    m = {16'h0, d[15:0]};
            default: m = d;
        endcase
        if (!tx_clr && tx_lvl < 32) begin
            exp_q.push_back(m);
            tx_lvl++;
        end
    endtask

    task automatic tx_pop();
        @(negedge clk); t_sh_req = 1;
        @(negedge clk); t_sh_req = 0;
        -> pop_ev;
    endtask

    // monitor: compares shifter output against the scoreboard
    always @(pop_ev) begin
        if (tx_run) begin
            if (exp_q.size() > 0) begin
                logic [31:0] e;
                e = exp_q.pop_front();
                tx_lvl--;
                chk(t_sh_rdata == e, "R3 order/width data", t_sh_rdata, e);
            end else begin
                chk(t_sh_rdata == 32'h0, "R7 empty pop data", t_sh_rdata, 32'h0);
            end
        end
    end

    task automatic rx_op(input logic [1:0] v);
        @(negedge clk); r_op_wr = 1; r_op_wdata = v;
        @(negedge clk); r_op_wr = 0;
    endtask

    task automatic rx_shpush(input logic [31:0] d);
        @(negedge clk); r_sh_req = 1; r_sh_wdata = d;
        @(negedge clk); r_sh_req = 0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog R1..all actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R1 reset state, transmit and receive builds
        chk(t_status == 9'h100, "R1 tx status", 32'(t_status), 32'h100);
        chk(!t_ovf && !t_udf, "R1 tx sticky flags", {t_ovf, t_udf}, 0);
        chk(t_thr == 1'b1, "R1 tx threshold 16 at level 0", 32'(t_thr), 1);
        chk(t_hit == 3'b111, "R1 tx default marks", 32'(t_hit), 32'b111);
        chk(r_status == 9'h100, "R1 rx status", 32'(r_status), 32'h100);
        chk(r_thr == 1'b0 && r_hit == 3'b000, "R1 rx threshold/marks", {r_thr, r_hit}, 0);

        // R5 stopped: shifter pop ignored, bus push still works
        tx_pop();
        chk(t_status == 9'h100 && !t_udf, "R5 stopped pop ignored", {t_udf, t_status}, 32'h100);
        tx_push(32'h1111_0001);
        tx_push(32'h2222_0002);
        tx_push(32'h3333_0003);
        chk(t_status == stat_of(3), "R5 bus push while stopped", 32'(t_status), 32'(stat_of(3)));
        tx_pop();
        chk(t_status == stat_of(3), "R5 stopped pop keeps level", 32'(t_status), 32'(stat_of(3)));

        // R4 start, then drain in order
        tx_op(2'b10);
        for (int i = 0; i < 3; i++) tx_pop();
        chk(t_status == stat_of(0), "R2 drained status", 32'(t_status), 32'(stat_of(0)));

        // R3 width codes
        tx_cfg(2'd0, 16); tx_push(32'hDEAD_BEEF);
        tx_cfg(2'd1, 16); tx_push(32'hDEAD_BEEF);
        tx_cfg(2'd3, 16); tx_push(32'hDEAD_BEEF);
        tx_cfg(2'd2, 16);
        for (int i = 0; i < 3; i++) tx_pop();

        // R2 R6 R8 R9 fill to full with level boundaries
        for (int i = 1; i <= 32; i++) begin
            tx_push(32'hA500_0000 + 32'(i));
            if (i == 4)  chk(t_hit == 3'b111, "R9 tx marks at 4", 32'(t_hit), 32'b111);
            if (i == 5)  chk(t_hit == 3'b011, "R9 tx marks at 5", 32'(t_hit), 32'b011);
            if (i == 15) chk(t_hit == 3'b001, "R9 tx marks at 15", 32'(t_hit), 32'b001);
            if (i == 16) chk(t_thr == 1'b1, "R8 tx thr at 16", 32'(t_thr), 1);
            if (i == 17) chk(t_thr == 1'b0, "R8 tx thr at 17", 32'(t_thr), 0);
            if (i == 28) chk(t_hit == 3'b000, "R9 tx marks at 28", 32'(t_hit), 0);
        end
        chk(t_status == 9'h0A0 && t_full && !t_empty, "R2 full status", 32'(t_status), 32'h0A0);
        tx_push(32'hBAD0_BAD0);
        chk(t_status == 9'h0A0 && t_ovf, "R6 drop on full", {t_ovf, t_status}, {1'b1, 9'h0A0});
        for (int i = 0; i < 32; i++) tx_pop();
        chk(t_status == 9'h100 && t_empty, "R2 empty after drain", 32'(t_status), 32'h100);

        // R7 pop at level 0 while running
        tx_pop();
        chk(t_udf == 1'b1, "R7 underflow latched", 32'(t_udf), 1);

        // R4 stop keeps contents, clear empties and holds
        tx_push(32'h0000_0C01);
        tx_push(32'h0000_0C02);
        tx_op(2'b00);
        chk(t_status == stat_of(2), "R4 stop keeps level", 32'(t_status), 32'(stat_of(2)));
        tx_op(2'b01);
        tx_push(32'h0000_0D00);
        chk(t_status == 9'h100 && !t_ovf && !t_udf, "R4 clear held", {t_ovf, t_udf, t_status}, 32'h100);
        tx_op(2'b00);
        tx_op(2'b10);
        tx_push(32'h0000_0E55);
        tx_pop();

        // R8 reprogrammed threshold, R9 reprogrammed marks
        tx_cfg(2'd2, 3);
        for (int i = 0; i < 2; i++) tx_push(32'h0000_0F00 + 32'(i));
        @(negedge clk); t_mark_wr = 1; t_mark_wdata = {5'd3, 5'd0, 5'd2, 5'd0, 5'd1};
        @(negedge clk); t_mark_wr = 0;
        chk(t_hit == 3'b110, "R9 written marks at 2", 32'(t_hit), 32'b110);
        tx_push(32'h0000_0F02);
        chk(t_thr == 1'b1, "R8 thr 3 at level 3", 32'(t_thr), 1);
        tx_push(32'h0000_0F03);
        chk(t_thr == 1'b0, "R8 thr 3 at level 4", 32'(t_thr), 0);
        for (int i = 0; i < 4; i++) tx_pop();

        // receive build: R5 gating, R8 ≥ threshold, R9 default marks, bus pop
        rx_shpush(32'h5A5A_0000);
        chk(r_status == 9'h100, "R5 rx stopped shifter push", 32'(r_status), 32'h100);
        rx_op(2'b10);
        for (int i = 1; i <= 16; i++) begin
            rx_shpush(32'h7700_0000 + 32'(i));
            if (i == 15) chk(r_thr == 1'b0, "R8 rx thr at 15", 32'(r_thr), 0);
            if (i == 16) chk(r_thr == 1'b1, "R8 rx thr at 16", 32'(r_thr), 1);
        end
        chk(r_hit == 3'b011, "R9 rx marks at 16", 32'(r_hit), 32'b011);
        @(negedge clk); r_bus_req = 1;
        @(negedge clk); r_bus_req = 0;
        chk(r_bus_rdata == 32'h7700_0001, "R3 rx bus pop order", r_bus_rdata, 32'h7700_0001);
        chk(r_status == stat_of(15), "R2 rx level after pop", 32'(r_status), 32'(stat_of(15)));

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule